// File: doc/BRIEF.md
# Quadrature Position Decoder with Double-Step Inference

This block follows a two-channel incremental encoder and keeps a signed position count. Both channel inputs are asynchronous to the block clock, so each one passes through a two-flop synchronizer. Once per clock, the block packs the synchronized levels and the levels it stored on the previous clock into a 4-bit transition code. A fixed 16-entry map turns that code into a step of +1, -1, +2, -2 or 0, and the step is added to a 32-bit position register. If a sample shows both channels changed, the block does not drop the move. It treats the sample as two quarter-steps and infers their direction from which phase pair was crossed.

After reset, a small state machine holds the block busy for a settle interval set by a parameter. The machine moves through three named states. In SETTLE it counts clocks and no counting happens. In CAPTURE it takes the synchronized channel levels as the starting reference. In TRACK it decodes and accumulates every clock. The transitions are: SETTLE to CAPTURE when the settle counter reaches its last cycle, and CAPTURE to TRACK unconditionally on the next clock. TRACK is left only through reset.

A load strobe overwrites the position with any value. When a load and a transition fall in the same cycle, the load wins, but the stored reference levels still advance.

Top module: `qdec_top`

## Requirements
- R1: While reset is asserted, and directly after it is released, `pos_out` is 0 and `busy` is 1.
- R2: A level change on `cha_in`/`chb_in` reaches `pos_out` on the third rising clock edge after it is applied. After two edges the old value is still shown.
- R3: After reset release, `busy` stays 1 for SETTLE_CYC+1 rising edges, then falls and never rises again before the next reset. Channel activity during that time does not change the position. The levels seen at the end become the reference.
- R4: The transition code is {current B, current A, previous B, previous A}, with previous A in bit 0. Codes 1, 7, 8 and 14 add one to the position.
- R5: Codes 2, 4, 11 and 13 subtract one from the position.
- R6: Codes 3 and 12 (both channels changed) add two.
- R7: Codes 6 and 9 (both channels changed) subtract two.
- R8: Codes 0, 5, 10 and 15 leave the position unchanged.
- R9: A cycle with `load_en` high makes `pos_out` equal to `load_val` from the next rising edge.
- R10: When a load and a nonzero transition meet at the same edge, the loaded value is kept and the transition is discarded. The reference levels are still updated, so the next move is decoded against the new levels.
- R11: The position wraps modulo 2^32 in both directions, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cha_in | input | 1 | Channel A, asynchronous |
| chb_in | input | 1 | Channel B, asynchronous |
| load_en | input | 1 | Position load strobe |
| load_val | input | 32 | Value written on a load |
| pos_out | output | 32 | Current signed position |
| busy | output | 1 | High until the settle interval ends and the reference is captured |

## Verification
A channel change is due at `pos_out` three rising edges after it is driven: two synchronizer stages, then the position register. A load is due one edge after the strobe, and `busy` falls on edge SETTLE_CYC+1 after reset release. The bench drives on falling edges and samples on falling edges exactly that many edges later. For the latency and load-collision cases it also samples one edge early, to confirm the old value is still present. Each table step waits the full three edges before comparing, so the decode of one step cannot mix with the next.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    typedef enum logic [1:0] {
        QS_SETTLE  = 2'd0,
        QS_CAPTURE = 2'd1,
        QS_TRACK   = 2'd2
    } qd_state_e;

    typedef logic signed [2:0] qd_step_t;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/qdec_step_map.sv
module qdec_step_map
    import qdec_pkg::*;
(
    input  logic [3:0] code,
    output qd_step_t   step
);
    always_comb begin
        unique case (code)
            4'd1, 4'd7, 4'd8, 4'd14:  step = 3'sd1;
            4'd2, 4'd4, 4'd11, 4'd13: step = -3'sd1;
            4'd3, 4'd12:              step = 3'sd2;
            4'd6, 4'd9:               step = -3'sd2;
            4'd0, 4'd5, 4'd10, 4'd15: step = 3'sd0;
        endcase
    end
endmodule

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
    import qdec_pkg::*;
#(
    parameter int SETTLE_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic capture,
    output logic track,
    output logic busy
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    qd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= QS_SETTLE;
        else        state_q <= state_d;
    end

    // settle counter
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (state_q == QS_SETTLE && cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_SETTLE:  if (cnt_q == CNT_LAST) state_d = QS_CAPTURE;
            QS_CAPTURE: state_d = QS_TRACK;
            QS_TRACK:   state_d = QS_TRACK;
            default:    state_d = QS_SETTLE;
        endcase
    end

    // outputs
    always_comb begin
        capture = 1'b0;
        track   = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            QS_SETTLE:  ;
            QS_CAPTURE: capture = 1'b1;
            QS_TRACK: begin
                track = 1'b1;
                busy  = 1'b0;
            end
            default: ;
        endcase
    end

    // R3: once tracking starts, busy stays low until reset
    p_busy_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int POS_W      = 32,
    parameter int SETTLE_CYC = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cha_in,
    input  logic             chb_in,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_val,
    output logic [POS_W-1:0] pos_out,
    output logic             busy
);
    logic [1:0]       lvl;      // bit0 = A, bit1 = B
    logic [1:0]       prev_q;
    logic [3:0]       code;
    qd_step_t         step;
    logic             capture, track;
    logic [POS_W-1:0] pos_q;

    qdec_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({chb_in, cha_in}),
        .q_sync  (lvl)
    );

    qdec_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .track   (track),
        .busy    (busy)
    );

    assign code = {lvl, prev_q};

    qdec_step_map u_map (
        .code (code),
        .step (step)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pos_q  <= '0;
        end else begin
            if (capture || track) prev_q <= lvl;
            if (load_en)          pos_q <= load_val;
            else if (track)       pos_q <= pos_q + {{(POS_W-3){step[2]}}, step};
        end
    end

    assign pos_out = pos_q;

    // R9: load value appears on the next edge
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> pos_out == $past(load_val));

    // R3: no counting while busy
    p_settle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_en) |=> $stable(pos_out));

    // R4/R5: one decode never moves more than two counts
    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_en) |=>
            ($signed(pos_out - $past(pos_out)) <= 2) &&
            ($signed(pos_out - $past(pos_out)) >= -2));

    // R8: unchanged levels leave the count alone
    p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_en && lvl == prev_q) |=> $stable(pos_out));

    // R7 (and R6): both channels flipped gives a nonzero move
    p_double_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_en && lvl == ~prev_q) |=> !$stable(pos_out));
endmodule

// File: tb/sim_qdec_top.sv
module sim_qdec_top;
    localparam int CLK_P  = 10;
    localparam int SETTLE = 16;
    localparam int NVEC   = 20;

    // {A, B, expected position}
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 32'hFFFF_FFFF},
        {1'b1, 1'b1, 32'hFFFF_FFFE},
        {1'b0, 1'b1, 32'hFFFF_FFFD},
        {1'b0, 1'b0, 32'hFFFF_FFFC},
        {1'b0, 1'b1, 32'hFFFF_FFFD},
        {1'b1, 1'b1, 32'hFFFF_FFFE},
        {1'b1, 1'b0, 32'hFFFF_FFFF},
        {1'b0, 1'b0, 32'h0000_0000},
        {1'b1, 1'b1, 32'h0000_0002},
        {1'b0, 1'b0, 32'h0000_0004},
        {1'b1, 1'b0, 32'h0000_0003},
        {1'b0, 1'b1, 32'h0000_0001},
        {1'b1, 1'b0, 32'hFFFF_FFFF},
        {1'b1, 1'b0, 32'hFFFF_FFFF},
        {1'b1, 1'b1, 32'hFFFF_FFFE},
        {1'b1, 1'b1, 32'hFFFF_FFFE},
        {1'b0, 1'b1, 32'hFFFF_FFFD},
        {1'b0, 1'b1, 32'hFFFF_FFFD},
        {1'b0, 1'b0, 32'hFFFF_FFFC},
        {1'b0, 1'b0, 32'hFFFF_FFFC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cha_in = 1'b0;
    logic        chb_in = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] load_val = '0;
    logic [31:0] pos_out;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    qdec_top #(.POS_W(32), .SETTLE_CYC(SETTLE)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cha_in   (cha_in),
        .chb_in   (chb_in),
        .load_en  (load_en),
        .load_val (load_val),
        .pos_out  (pos_out),
        .busy     (busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic signed [31:0] d);
        case (d)
            1:       return "R4 +1";
            -1:      return "R5 -1";
            2:       return "R6 +2";
            -2:      return "R7 -2";
            default: return "R8 hold";
        endcase
    endfunction

    task automatic mv(input logic a, input logic b);
        cha_in = a;
        chb_in = b;
        repeat (3) @(negedge clk);
    endtask

    task automatic ld(input logic [31:0] v);
        load_en  = 1'b1;
        load_val = v;
        @(negedge clk);
        load_en  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev_exp;
        repeat (3) @(negedge clk);
        chk("R1 pos in reset", pos_out, 32'd0);
        chk("R1 busy in reset", {31'd0, busy}, 32'd1);
        rst_n = 1'b1;
        chk("R1 busy after release", {31'd0, busy}, 32'd1);

        // channel activity during settle, captured as reference 11
        repeat (2) @(negedge clk);
        cha_in = 1'b1;
        chb_in = 1'b1;
        repeat (SETTLE - 2) @(negedge clk);
        chk("R3 busy at last settle edge", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R3 busy low after capture", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R3 no count from settle activity", pos_out, 32'd0);
        mv(1'b0, 1'b0);
        chk("R3 reference 11 then 00 gives R6 +2", pos_out, 32'd2);

        ld(32'd0);
        chk("R9 load zero", pos_out, 32'd0);

        // table walk from reference 00
        prev_exp = 32'd0;
        for (int i = 0; i < NVEC; i++) begin
            mv(VEC[i][33], VEC[i][32]);
            chk(tag_of(VEC[i][31:0] - prev_exp), pos_out, VEC[i][31:0]);
            prev_exp = VEC[i][31:0];
        end

        // R10: load collides with a transition, now levels 00, pos -4
        cha_in = 1'b1;
        repeat (2) @(negedge clk);
        ld(32'd100);
        chk("R10 load wins", pos_out, 32'd100);
        repeat (3) @(negedge clk);
        chk("R10 transition discarded", pos_out, 32'd100);
        mv(1'b1, 1'b1);
        chk("R10 reference advanced", pos_out, 32'd99);

        // R2: latency from 11 to 10 (+1)
        cha_in = 1'b1;
        chb_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 unchanged after two edges", pos_out, 32'd99);
        @(negedge clk);
        chk("R2 updated on third edge", pos_out, 32'd100);

        // R11: wrap both ways
        ld(32'h7FFF_FFFF);
        chk("R9 load max", pos_out, 32'h7FFF_FFFF);
        mv(1'b0, 1'b0);
        chk("R11 wrap up", pos_out, 32'h8000_0000);
        ld(32'h8000_0000);
        mv(1'b1, 1'b0);
        chk("R11 wrap down", pos_out, 32'h7FFF_FFFF);
        ld(32'd1);
        mv(1'b0, 1'b1);
        chk("R11 wrap below zero by two", pos_out, 32'hFFFF_FFFF);

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pos after re-reset", pos_out, 32'd0);
        chk("R1 busy after re-reset", {31'd0, busy}, 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule